// File: doc/BRIEF.md
# Three-Colour Linear CCD Drive Timing Generator

This block turns one system clock into the digital drive waveforms of a three-row colour linear CCD: one transfer-gate pulse shared by the red, green and blue rows, the complementary shift-register clock pair, and the reset-gate pulse that sets the pixel rate. For the sampling logic downstream it also provides the index of the pixel now on the outputs, a strobe on the first pixel of each line, and three flags that sort that pixel into the optical-black, valid or trailing invalid region.

Every time is a parameter counted in system-clock cycles. These are the pixel period, the reset pulse width and its clearance before the next shift edge, the shift-clock hold before and after transfer, and the transfer width. The region sizes and the readout length per line are parameters counted in pixels. A single start pulse arms the generator. After that it runs line after line with no further input. Each line is a transfer interval followed by a readout of equal-length pixel periods. The drive pins are plain control levels, so there is no handshake at any edge.

Top module: `ccd_timing_gen`

## Requirements
- R1: While reset is asserted, and after reset until a start pulse is sampled, the outputs rest at: transfer gate low, phi1 high, phi2 low, reset gate low, index 0, strobe and all flags low.
- R2: From the edge that samples start, phi1 is high and phi2 low for exactly SETUP_CYC cycles before the transfer gate rises. Every later line repeats this.
- R3: The transfer gate stays high for exactly TG_CYC cycles per line.
- R4: After the transfer gate falls, phi1 stays high and phi2 low for at least HOLD_CYC cycles. Readout then starts on the first pixel-period boundary that follows.
- R5: During readout, phi1 is high in the first PIX_CYC/2 cycles of each pixel period and phi2 in the rest. The two are never high together.
- R6: The reset gate is high for RB_W cycles in every pixel period, and it keeps running through the setup, transfer and hold intervals. It falls exactly RB_GAP_CYC cycles before the mid-period shift edge, with pixel periods counted from the start edge.
- R7: During readout the pixel index counts up from 0, one step per pixel period, and it is 0 at all other times. The line-start strobe is high only in the first cycle of pixel 0.
- R8: The ob flag is high for index values in [LEAD_PIX, LEAD_PIX+OB_PIX). The valid flag covers the next VALID_PIX values and the invalid flag the next INV_PIX values. At all other index values, and outside readout, no flag is high. At most one flag is ever high.
- R9: A readout lasts max(INTEG_PIX, LINE_PIX) pixel periods. A shorter integration setting is raised to the full line. The next line's setup begins in the cycle after the last pixel.
- R10: A start pulse that arrives while the generator is running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous arm pulse |
| tg_o | output | 1 | Transfer gate, shared by all three rows |
| phi1_o | output | 1 | Shift clock phase 1 |
| phi2_o | output | 1 | Shift clock phase 2 |
| rb_o | output | 1 | Reset-gate pulse |
| pix_idx_o | output | IDX_W | Index of the pixel in readout |
| line_start_o | output | 1 | First cycle of pixel 0 of a line |
| ob_flag_o | output | 1 | Pixel is optical black |
| valid_flag_o | output | 1 | Pixel is a valid photocell |
| invalid_flag_o | output | 1 | Pixel is in the trailing invalid group |

## Verification
The bench builds two copies with a 12-cycle pixel period, 5/12/6-cycle setup, transfer and hold, a 2-cycle reset pulse with a 2-cycle clearance, and a 13-pixel line split 2/3/6/2. One copy has an integration setting of 4 pixels, which must be raised to 13. The other has 16 pixels, which adds three unflagged pixels. With these sizes every output of every cycle in three complete lines can be compared with an arithmetic timeline. That timeline includes the hold stretch that aligns readout to a pixel boundary, the region edges, the line wrap, and a start pulse sent in the middle of a run.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_SETUP = 3'd1,
    SEQ_XFER  = 3'd2,
    SEQ_HOLD  = 3'd3,
    SEQ_READ  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/ccdtg_pix_phase.sv
// Pixel-period phase counter and reset-gate pulse placement.
module ccdtg_pix_phase #(
  parameter int PIX_CYC    = 50,
  parameter int RB_W       = 3,
  parameter int RB_GAP_CYC = 13,
  localparam int PC_W  = $clog2(PIX_CYC),
  localparam int HALF  = PIX_CYC / 2,
  localparam int RB_HI = HALF - RB_GAP_CYC,
  localparam int RB_LO = RB_HI - RB_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  output logic            wrap_o,
  output logic            boundary_o,
  output logic            first_half_o,
  output logic            rb_o
);
  logic [PC_W-1:0] pc_q;
  logic            rb_lo_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            pc_q <= '0;
    else if (!run || wrap_o)               pc_q <= '0;
    else                                   pc_q <= pc_q + 1'b1;
  end

  assign wrap_o       = run && (pc_q == PC_W'(PIX_CYC - 1));
  assign boundary_o   = run && (pc_q == '0);
  assign first_half_o = pc_q < PC_W'(HALF);

  generate
    if (RB_LO == 0) begin : g_rb_at_zero
      assign rb_lo_ok = 1'b1;
    end else begin : g_rb_offset
      assign rb_lo_ok = pc_q >= PC_W'(RB_LO);
    end
  endgenerate

  assign rb_o = run && rb_lo_ok && (pc_q < PC_W'(RB_HI));
endmodule

// File: rtl/ccdtg_line_seq.sv
// Line sequencer: setup, transfer, hold (aligned to a pixel boundary), readout.
module ccdtg_line_seq
  import ccdtg_pkg::*;
#(
  parameter int SETUP_CYC = 50,
  parameter int TG_CYC    = 500,
  parameter int HOLD_CYC  = 50,
  parameter int READ_PIX  = 5369,
  parameter int IDX_W     = 13,
  localparam int MAX_A = (SETUP_CYC > TG_CYC) ? SETUP_CYC : TG_CYC,
  localparam int MAX_T = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC,
  localparam int CNT_W = $clog2(MAX_T + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wrap,
  output seq_state_e       state_o,
  output logic [IDX_W-1:0] idx_o
);
  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start) begin
          st_q  <= SEQ_SETUP;
          cnt_q <= '0;
        end
        SEQ_SETUP: begin
          if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
            st_q  <= SEQ_XFER;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SEQ_XFER: begin
          if (cnt_q == CNT_W'(TG_CYC - 1)) begin
            st_q  <= SEQ_HOLD;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SEQ_HOLD: begin
          if (cnt_q != CNT_W'(HOLD_CYC - 1)) cnt_q <= cnt_q + 1'b1;
          else if (wrap) begin
            st_q  <= SEQ_READ;
            idx_q <= '0;
          end
        end
        SEQ_READ: if (wrap) begin
          if (idx_q == IDX_W'(READ_PIX - 1)) begin
            st_q  <= SEQ_SETUP;
            cnt_q <= '0;
            idx_q <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/ccdtg_region_dec.sv
// Sorts the current pixel index into optical-black, valid and invalid regions.
module ccdtg_region_dec #(
  parameter int LEAD_PIX  = 15,
  parameter int OB_PIX    = 49,
  parameter int VALID_PIX = 5300,
  parameter int INV_PIX   = 5,
  parameter int IDX_W     = 13,
  localparam int OB_END  = LEAD_PIX + OB_PIX,
  localparam int VAL_END = OB_END + VALID_PIX,
  localparam int INV_END = VAL_END + INV_PIX
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             active,
  output logic             ob_o,
  output logic             valid_o,
  output logic             inv_o
);
  logic past_lead;

  generate
    if (LEAD_PIX == 0) begin : g_no_lead
      assign past_lead = 1'b1;
    end else begin : g_lead
      assign past_lead = idx >= IDX_W'(LEAD_PIX);
    end
  endgenerate

  assign ob_o    = active && past_lead && (idx < IDX_W'(OB_END));
  assign valid_o = active && (idx >= IDX_W'(OB_END)) && (idx < IDX_W'(VAL_END));
  assign inv_o   = active && (idx >= IDX_W'(VAL_END)) && (idx < IDX_W'(INV_END));
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccdtg_pkg::*;
#(
  parameter int PIX_CYC    = 50,
  parameter int RB_W       = 3,
  parameter int RB_GAP_CYC = 13,
  parameter int SETUP_CYC  = 50,
  parameter int TG_CYC     = 500,
  parameter int HOLD_CYC   = 50,
  parameter int LEAD_PIX   = 15,
  parameter int OB_PIX     = 49,
  parameter int VALID_PIX  = 5300,
  parameter int INV_PIX    = 5,
  parameter int INTEG_PIX  = 5369,
  localparam int LINE_PIX = LEAD_PIX + OB_PIX + VALID_PIX + INV_PIX,
  localparam int READ_PIX = (INTEG_PIX > LINE_PIX) ? INTEG_PIX : LINE_PIX,
  localparam int IDX_W    = $clog2(READ_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             tg_o,
  output logic             phi1_o,
  output logic             phi2_o,
  output logic             rb_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             line_start_o,
  output logic             ob_flag_o,
  output logic             valid_flag_o,
  output logic             invalid_flag_o
);
  seq_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             run, wrap, boundary, first_half, reading;

  assign run     = state != SEQ_IDLE;
  assign reading = state == SEQ_READ;

  ccdtg_pix_phase #(
    .PIX_CYC(PIX_CYC), .RB_W(RB_W), .RB_GAP_CYC(RB_GAP_CYC)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run),
    .wrap_o(wrap), .boundary_o(boundary), .first_half_o(first_half), .rb_o(rb_o)
  );

  ccdtg_line_seq #(
    .SETUP_CYC(SETUP_CYC), .TG_CYC(TG_CYC), .HOLD_CYC(HOLD_CYC),
    .READ_PIX(READ_PIX), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wrap(wrap),
    .state_o(state), .idx_o(idx)
  );

  ccdtg_region_dec #(
    .LEAD_PIX(LEAD_PIX), .OB_PIX(OB_PIX), .VALID_PIX(VALID_PIX),
    .INV_PIX(INV_PIX), .IDX_W(IDX_W)
  ) u_region (
    .idx(idx), .active(reading),
    .ob_o(ob_flag_o), .valid_o(valid_flag_o), .inv_o(invalid_flag_o)
  );

  assign tg_o         = state == SEQ_XFER;
  assign phi1_o       = !reading || first_half;
  assign phi2_o       = reading && !first_half;
  assign pix_idx_o    = idx;
  assign line_start_o = reading && boundary && (idx == '0);
endmodule

// File: rtl/ccd_timing_gen_chk.sv
// Pulse-width and gap checks on the drive outputs, measured with counters.
module ccd_timing_gen_chk #(
  parameter int PIX_CYC    = 50,
  parameter int RB_W       = 3,
  parameter int RB_GAP_CYC = 13,
  parameter int SETUP_CYC  = 50,
  parameter int TG_CYC     = 500,
  parameter int HOLD_CYC   = 50,
  parameter int READ_PIX   = 5369,
  parameter int IDX_W      = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tg_o,
  input logic             phi1_o,
  input logic             phi2_o,
  input logic             rb_o,
  input logic [IDX_W-1:0] pix_idx_o,
  input logic             line_start_o,
  input logic             ob_flag_o,
  input logic             valid_flag_o,
  input logic             invalid_flag_o
);
  localparam int SAT = 1 << 20;

  int  ph1_hi_cnt, tg_hi_cnt, after_tg_cnt, rb_lo_cnt, rb_hi_cnt, rb_per_cnt;
  logic rb_q, rb_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1_hi_cnt   <= SAT;
      tg_hi_cnt    <= 0;
      after_tg_cnt <= SAT;
      rb_lo_cnt    <= SAT;
      rb_hi_cnt    <= 0;
      rb_per_cnt   <= 0;
      rb_q         <= 1'b0;
      rb_seen      <= 1'b0;
    end else begin
      ph1_hi_cnt   <= !phi1_o ? 0 : (ph1_hi_cnt < SAT ? ph1_hi_cnt + 1 : SAT);
      tg_hi_cnt    <= !tg_o ? 0 : tg_hi_cnt + 1;
      after_tg_cnt <= tg_o ? 0 : (after_tg_cnt < SAT ? after_tg_cnt + 1 : SAT);
      rb_lo_cnt    <= rb_o ? 0 : (rb_lo_cnt < SAT ? rb_lo_cnt + 1 : SAT);
      rb_hi_cnt    <= !rb_o ? 0 : rb_hi_cnt + 1;
      rb_per_cnt   <= (rb_o && !rb_q) ? 1 : (rb_per_cnt < SAT ? rb_per_cnt + 1 : SAT);
      rb_q         <= rb_o;
      if (rb_o && !rb_q) rb_seen <= 1'b1;
    end
  end

  p_setup_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tg_o) |-> ph1_hi_cnt >= SETUP_CYC);

  p_tg_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tg_o) |-> tg_hi_cnt == TG_CYC);

  p_tg_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tg_o |-> (phi1_o && !phi2_o));

  p_hold_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tg_o && after_tg_cnt < HOLD_CYC) |-> (phi1_o && !phi2_o));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1_o && phi2_o));

  p_rb_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_o) |-> rb_hi_cnt == RB_W);

  p_rb_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi1_o) || $rose(phi2_o)) |-> rb_lo_cnt >= RB_GAP_CYC);

  p_rb_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rb_o) && rb_seen) |-> rb_per_cnt == PIX_CYC);

  p_strobe_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_o |-> (pix_idx_o == '0 && !tg_o));

  p_flags_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ob_flag_o, valid_flag_o, invalid_flag_o}));

  p_flags_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tg_o |-> !(ob_flag_o || valid_flag_o || invalid_flag_o));

  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pix_idx_o) < READ_PIX);
endmodule

bind ccd_timing_gen ccd_timing_gen_chk #(
  .PIX_CYC(PIX_CYC), .RB_W(RB_W), .RB_GAP_CYC(RB_GAP_CYC),
  .SETUP_CYC(SETUP_CYC), .TG_CYC(TG_CYC), .HOLD_CYC(HOLD_CYC),
  .READ_PIX(READ_PIX), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tg_o(tg_o), .phi1_o(phi1_o), .phi2_o(phi2_o),
  .rb_o(rb_o), .pix_idx_o(pix_idx_o), .line_start_o(line_start_o),
  .ob_flag_o(ob_flag_o), .valid_flag_o(valid_flag_o), .invalid_flag_o(invalid_flag_o)
);

// File: tb/ccd_timing_gen_tb.sv
module ccd_timing_gen_tb;
  localparam int P = 12, RBW = 2, GAP = 2, S = 5, T = 12, H = 6;
  localparam int LEAD = 2, OB = 3, VAL = 6, INV = 2;
  localparam int LINE = LEAD + OB + VAL + INV;
  localparam int NA = 13, NB = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic tg_a, p1_a, p2_a, rb_a, ls_a, ob_a, va_a, iv_a;
  logic tg_b, p1_b, p2_b, rb_b, ls_b, ob_b, va_b, iv_b;
  logic [3:0] idx_a, idx_b;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  ccd_timing_gen #(
    .PIX_CYC(P), .RB_W(RBW), .RB_GAP_CYC(GAP), .SETUP_CYC(S), .TG_CYC(T),
    .HOLD_CYC(H), .LEAD_PIX(LEAD), .OB_PIX(OB), .VALID_PIX(VAL),
    .INV_PIX(INV), .INTEG_PIX(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tg_o(tg_a), .phi1_o(p1_a),
    .phi2_o(p2_a), .rb_o(rb_a), .pix_idx_o(idx_a), .line_start_o(ls_a),
    .ob_flag_o(ob_a), .valid_flag_o(va_a), .invalid_flag_o(iv_a)
  );

  ccd_timing_gen #(
    .PIX_CYC(P), .RB_W(RBW), .RB_GAP_CYC(GAP), .SETUP_CYC(S), .TG_CYC(T),
    .HOLD_CYC(H), .LEAD_PIX(LEAD), .OB_PIX(OB), .VALID_PIX(VAL),
    .INV_PIX(INV), .INTEG_PIX(NB)
  ) u_dut_long (
    .clk(clk), .rst_n(rst_n), .start(start), .tg_o(tg_b), .phi1_o(p1_b),
    .phi2_o(p2_b), .rb_o(rb_b), .pix_idx_o(idx_b), .line_start_o(ls_b),
    .ob_flag_o(ob_b), .valid_flag_o(va_b), .invalid_flag_o(iv_b)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string nm, input logic tg, p1, p2, rb, ls,
                          ob, va, iv, input logic [3:0] idx);
    cmp({nm, " R1 tg"}, tg, 0);   cmp({nm, " R1 phi1"}, p1, 1);
    cmp({nm, " R1 phi2"}, p2, 0); cmp({nm, " R1 rb"}, rb, 0);
    cmp({nm, " R1 strobe"}, ls, 0);
    cmp({nm, " R1 flags"}, {ob, va, iv}, 0);
    cmp({nm, " R1 idx"}, idx, 0);
  endtask

  // Expected outputs n cycles after the start edge, N = readout pixels per line.
  task automatic chk_run(input string nm, input int n, input int N, input bit late,
                         input logic tg, p1, p2, rb, ls, ob, va, iv,
                         input logic [3:0] idx);
    int n0, len, m, pc, pi, ep1;
    bit rd;
    string sfx, phreq;
    n0  = ((S + T + H + P - 1) / P) * P;
    len = n0 + N * P;
    m   = n % len;
    pc  = m % P;
    rd  = m >= n0;
    pi  = rd ? (m - n0) / P : 0;
    ep1 = rd ? int'(pc < P / 2) : 1;
    sfx = late ? $sformatf(" R10 n=%0d", n) : $sformatf(" n=%0d", n);
    if (m < S)           phreq = "R2";
    else if (m < S + T)  phreq = "R3";
    else if (m < n0)     phreq = "R4";
    else                 phreq = "R5";
    cmp({nm, " R3 R9 tg", sfx}, tg, int'(m >= S && m < S + T));
    cmp({nm, " ", phreq, " phi1", sfx}, p1, ep1);
    cmp({nm, " ", phreq, " phi2", sfx}, p2, 1 - ep1);
    cmp({nm, " R6 rb", sfx}, rb, int'(pc >= P / 2 - GAP - RBW && pc < P / 2 - GAP));
    cmp({nm, " R7 idx", sfx}, idx, pi);
    cmp({nm, " R7 strobe", sfx}, ls, int'(rd && pi == 0 && pc == 0));
    cmp({nm, " R8 ob", sfx}, ob, int'(rd && pi >= LEAD && pi < LEAD + OB));
    cmp({nm, " R8 valid", sfx}, va, int'(rd && pi >= LEAD + OB && pi < LEAD + OB + VAL));
    cmp({nm, " R8 invalid", sfx}, iv, int'(rd && pi >= LEAD + OB + VAL && pi < LINE));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("A", tg_a, p1_a, p2_a, rb_a, ls_a, ob_a, va_a, iv_a, idx_a);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk_idle("A", tg_a, p1_a, p2_a, rb_a, ls_a, ob_a, va_a, iv_a, idx_a);
      chk_idle("B", tg_b, p1_b, p2_b, rb_b, ls_b, ob_b, va_b, iv_b, idx_b);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 3 * (24 + NB * P); n++) begin
      if (n < 3 * (24 + NA * P))
        chk_run("A", n, NA, n > 101, tg_a, p1_a, p2_a, rb_a, ls_a, ob_a, va_a, iv_a, idx_a);
      chk_run("B", n, NB, n > 101, tg_b, p1_b, p2_b, rb_b, ls_b, ob_b, va_b, iv_b, idx_b);
      if (n == 100) start = 1'b1;
      if (n == 101) start = 1'b0;
      @(negedge clk);
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("A", tg_a, p1_a, p2_a, rb_a, ls_a, ob_a, va_a, iv_a, idx_a);
    chk_idle("B", tg_b, p1_b, p2_b, rb_b, ls_b, ob_b, va_b, iv_b, idx_b);
    rst_n = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule